// File: doc/BRIEF.md
# Display Refresh Scan Address Generator

This block walks a DRAM array and an oscilloscope dot display in lock step. Each display/refresh slot is marked by a one-cycle strobe. On each strobe a bit counter steps through the 18 bits of a data word. When the bit counter wraps, a word counter steps through the 44 words of a frame. Two words make one display line, so a frame holds 22 lines. The same counter values serve as the refresh address for the DRAM and as the dot position on the scope.

The upper 16 lines show one page of memory. An external page-select field chooses the page, and the block forms the memory word address from that field and the low word-counter bits. The remaining 6 lines show register-file contents, and the block forms a register read address for them. A horizontal sync marks the first slot of every line. A vertical sync marks the first slot of every frame. The block picks the addressed bit from the memory data or the register data, whichever matches the current line. When that bit is 1, it emits a one-cycle Z-axis pulse as the slot closes. The memory, the register file and the analog raster stage lie outside the block, and their data arrive on input ports.

Top module: `scanAddrGen`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `bitAddr`, `wordAddr` and `videoPulse` are 0.
- R2: Each clock edge with `slotTick` high moves `bitAddr` one step, from 17 back to 0. Edges with `slotTick` low leave both counters unchanged.
- R3: `wordAddr` increments only on a `slotTick` edge where `bitAddr` is 17. It wraps from 43 to 0.
- R4: `lineNum` equals `wordAddr` shifted right by one, so it runs 0 to 21.
- R5: `memAddr` is `{pageSel, wordAddr[4:0]}`. `srcReg` is 0 while `wordAddr` is below 32 (lines 0 to 15).
- R6: While `wordAddr` is 32 or more (lines 16 to 21), `srcReg` is 1 and `regAddr` equals `wordAddr - 32`. On memory lines `regAddr` is 0.
- R7: `hSync` is 1 exactly when `bitAddr` is 0 and `wordAddr` is even.
- R8: `vSync` is 1 exactly when `bitAddr` and `wordAddr` are both 0.
- R9: On the cycle after a `slotTick` edge, `videoPulse` equals the selected bit at that edge. The selected bit is `memData[bitAddr]` on memory lines and `regData[bitAddr]` on register lines. On every other cycle `videoPulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| slotTick | input | 1 | High for the last cycle of each display/refresh slot |
| pageSel | input | 4 | Memory page shown on lines 0 to 15 |
| memData | input | 18 | Memory word at `memAddr` |
| regData | input | 18 | Register word at `regAddr` |
| bitAddr | output | 5 | Bit counter, 0 to 17 |
| wordAddr | output | 6 | Word counter, 0 to 43 |
| lineNum | output | 5 | Display line, 0 to 21 |
| memAddr | output | 9 | Memory word address |
| srcReg | output | 1 | High on register lines |
| regAddr | output | 4 | Register read address |
| hSync | output | 1 | Line start marker |
| vSync | output | 1 | Frame start marker |
| videoPulse | output | 1 | Z-axis dot pulse |

## Verification
The bench targets the two wrap points: bit 17 to 0, and word 43 to 0 at the end of a frame. A counter built as a power-of-two modulus would run on to 31 or 63, and the line or frame count would drift. The bench also targets the change of data source at word 32, and back to memory at frame wrap. An off-by-one there would show register data on line 15, or a register address offset by one. Slots arrive both back to back and with idle gaps between them. A design that advanced without a strobe, or that stretched or delayed the video pulse, would put dots in the wrong place. A reset in the middle of a frame must also restart the scan from the frame origin.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic advBit;   // step the bit counter, latch the video bit
    logic wrapBit;  // bit counter returns to zero
    logic advWord;  // step the word counter
    logic wrapWord; // word counter returns to zero
  } scanStrobe_t;
endpackage

// File: rtl/scanCtrl.sv
module scanCtrl
  import scan_pkg::*;
(
  input  logic        slotTick,
  input  logic        bitAtEnd,
  input  logic        wordAtEnd,
  output scanStrobe_t strobe
);
  always_comb begin
    strobe.advBit   = slotTick;
    strobe.wrapBit  = slotTick && bitAtEnd;
    strobe.advWord  = slotTick && bitAtEnd;
    strobe.wrapWord = slotTick && bitAtEnd && wordAtEnd;
  end
endmodule

// File: rtl/scanPath.sv
module scanPath
  import scan_pkg::*;
#(
  parameter int BITS_PER_WORD   = 18,
  parameter int WORDS_PER_FRAME = 44,
  parameter int MEM_LINES       = 16,
  parameter int PAGE_W          = 4,
  localparam int BIT_W     = $clog2(BITS_PER_WORD),
  localparam int WORD_W    = $clog2(WORDS_PER_FRAME),
  localparam int LINE_W    = WORD_W - 1,
  localparam int MEM_WORDS = 2 * MEM_LINES,
  localparam int MOFF_W    = $clog2(MEM_WORDS),
  localparam int REG_WORDS = WORDS_PER_FRAME - MEM_WORDS,
  localparam int REG_W     = $clog2(REG_WORDS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  scanStrobe_t              strobe,
  input  logic [PAGE_W-1:0]        pageSel,
  input  logic [BITS_PER_WORD-1:0] memData,
  input  logic [BITS_PER_WORD-1:0] regData,
  output logic                     bitAtEnd,
  output logic                     wordAtEnd,
  output logic [BIT_W-1:0]         bitAddr,
  output logic [WORD_W-1:0]        wordAddr,
  output logic [LINE_W-1:0]        lineNum,
  output logic [PAGE_W+MOFF_W-1:0] memAddr,
  output logic                     srcReg,
  output logic [REG_W-1:0]         regAddr,
  output logic                     hSync,
  output logic                     vSync,
  output logic                     videoPulse
);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(BITS_PER_WORD - 1);
  localparam logic [WORD_W-1:0] WORD_LAST = WORD_W'(WORDS_PER_FRAME - 1);
  localparam logic [WORD_W-1:0] REG_BASE  = WORD_W'(MEM_WORDS);

  logic [WORD_W-1:0] regDiff;
  logic              selBit;

  assign bitAtEnd  = (bitAddr == BIT_LAST);
  assign wordAtEnd = (wordAddr == WORD_LAST);

  // bit counter
  always_ff @(posedge clk) begin
    if (!rstN)               bitAddr <= '0;
    else if (strobe.wrapBit) bitAddr <= '0;
    else if (strobe.advBit)  bitAddr <= bitAddr + BIT_W'(1);
  end

  // word counter
  always_ff @(posedge clk) begin
    if (!rstN)                wordAddr <= '0;
    else if (strobe.wrapWord) wordAddr <= '0;
    else if (strobe.advWord)  wordAddr <= wordAddr + WORD_W'(1);
  end

  // address formation
  always_comb begin
    lineNum = wordAddr[WORD_W-1:1];
    srcReg  = (wordAddr >= REG_BASE);
    memAddr = {pageSel, MOFF_W'(wordAddr)};
    regDiff = wordAddr - REG_BASE;
    regAddr = srcReg ? REG_W'(regDiff) : '0;
  end

  // raster markers
  always_comb begin
    hSync = (bitAddr == '0) && !wordAddr[0];
    vSync = (bitAddr == '0) && (wordAddr == '0);
  end

  // video source select and end-of-slot pulse
  assign selBit = srcReg ? regData[bitAddr] : memData[bitAddr];

  always_ff @(posedge clk) begin
    if (!rstN)              videoPulse <= 1'b0;
    else if (strobe.advBit) videoPulse <= selBit;
    else                    videoPulse <= 1'b0;
  end
endmodule

// File: rtl/scanAddrGen.sv
module scanAddrGen
  import scan_pkg::*;
#(
  parameter int BITS_PER_WORD   = 18,
  parameter int WORDS_PER_FRAME = 44,
  parameter int MEM_LINES       = 16,
  parameter int PAGE_W          = 4,
  localparam int BIT_W     = $clog2(BITS_PER_WORD),
  localparam int WORD_W    = $clog2(WORDS_PER_FRAME),
  localparam int LINE_W    = WORD_W - 1,
  localparam int MEM_WORDS = 2 * MEM_LINES,
  localparam int MOFF_W    = $clog2(MEM_WORDS),
  localparam int REG_WORDS = WORDS_PER_FRAME - MEM_WORDS,
  localparam int REG_W     = $clog2(REG_WORDS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     slotTick,
  input  logic [PAGE_W-1:0]        pageSel,
  input  logic [BITS_PER_WORD-1:0] memData,
  input  logic [BITS_PER_WORD-1:0] regData,
  output logic [BIT_W-1:0]         bitAddr,
  output logic [WORD_W-1:0]        wordAddr,
  output logic [LINE_W-1:0]        lineNum,
  output logic [PAGE_W+MOFF_W-1:0] memAddr,
  output logic                     srcReg,
  output logic [REG_W-1:0]         regAddr,
  output logic                     hSync,
  output logic                     vSync,
  output logic                     videoPulse
);
  scanStrobe_t strobe;
  logic        bitAtEnd;
  logic        wordAtEnd;

  scanCtrl u_ctrl (
    .slotTick  (slotTick),
    .bitAtEnd  (bitAtEnd),
    .wordAtEnd (wordAtEnd),
    .strobe    (strobe)
  );

  scanPath #(
    .BITS_PER_WORD   (BITS_PER_WORD),
    .WORDS_PER_FRAME (WORDS_PER_FRAME),
    .MEM_LINES       (MEM_LINES),
    .PAGE_W          (PAGE_W)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .pageSel    (pageSel),
    .memData    (memData),
    .regData    (regData),
    .bitAtEnd   (bitAtEnd),
    .wordAtEnd  (wordAtEnd),
    .bitAddr    (bitAddr),
    .wordAddr   (wordAddr),
    .lineNum    (lineNum),
    .memAddr    (memAddr),
    .srcReg     (srcReg),
    .regAddr    (regAddr),
    .hSync      (hSync),
    .vSync      (vSync),
    .videoPulse (videoPulse)
  );
endmodule

// File: rtl/scanAddrGen_chk.sv
module scanAddrGen_chk #(
  parameter int BITS_PER_WORD   = 18,
  parameter int WORDS_PER_FRAME = 44,
  parameter int MEM_LINES       = 16,
  parameter int PAGE_W          = 4,
  localparam int BIT_W     = $clog2(BITS_PER_WORD),
  localparam int WORD_W    = $clog2(WORDS_PER_FRAME),
  localparam int LINE_W    = WORD_W - 1,
  localparam int MEM_WORDS = 2 * MEM_LINES,
  localparam int MOFF_W    = $clog2(MEM_WORDS),
  localparam int REG_W     = $clog2(WORDS_PER_FRAME - MEM_WORDS)
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     slotTick,
  input logic [PAGE_W-1:0]        pageSel,
  input logic [BITS_PER_WORD-1:0] memData,
  input logic [BITS_PER_WORD-1:0] regData,
  input logic [BIT_W-1:0]         bitAddr,
  input logic [WORD_W-1:0]        wordAddr,
  input logic [LINE_W-1:0]        lineNum,
  input logic [PAGE_W+MOFF_W-1:0] memAddr,
  input logic                     srcReg,
  input logic [REG_W-1:0]         regAddr,
  input logic                     hSync,
  input logic                     vSync,
  input logic                     videoPulse
);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(BITS_PER_WORD - 1);
  localparam logic [WORD_W-1:0] WORD_LAST = WORD_W'(WORDS_PER_FRAME - 1);

  a_r2_bit_range: assert property (@(posedge clk) disable iff (!rstN)
    bitAddr <= BIT_LAST);

  a_r3_word_range: assert property (@(posedge clk) disable iff (!rstN)
    wordAddr <= WORD_LAST);

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !slotTick |=> $stable(bitAddr) && $stable(wordAddr));

  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    (slotTick && bitAddr != BIT_LAST) |=>
      (bitAddr == $past(bitAddr) + BIT_W'(1)) && $stable(wordAddr));

  a_r3_word_step: assert property (@(posedge clk) disable iff (!rstN)
    (slotTick && bitAddr == BIT_LAST && wordAddr != WORD_LAST) |=>
      bitAddr == '0 && wordAddr == $past(wordAddr) + WORD_W'(1));

  a_r3_frame_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (slotTick && bitAddr == BIT_LAST && wordAddr == WORD_LAST) |=>
      bitAddr == '0 && wordAddr == '0);

  a_r8_vsync_in_hsync: assert property (@(posedge clk) disable iff (!rstN)
    vSync |-> hSync);

  a_r9_pulse_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    videoPulse |-> $past(slotTick));

  a_r6_reg_addr_range: assert property (@(posedge clk) disable iff (!rstN)
    srcReg |-> lineNum >= LINE_W'(MEM_LINES));
endmodule

bind scanAddrGen scanAddrGen_chk #(
  .BITS_PER_WORD   (BITS_PER_WORD),
  .WORDS_PER_FRAME (WORDS_PER_FRAME),
  .MEM_LINES       (MEM_LINES),
  .PAGE_W          (PAGE_W)
) u_chk (.*);

// File: tb/scanAddrGen_tb.sv
`timescale 1ns/1ps
module scanAddrGen_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slotTick = 1'b0;
  logic [3:0]  pageSel = '0;
  logic [17:0] memData = '0;
  logic [17:0] regData = '0;
  logic [4:0]  bitAddr;
  logic [5:0]  wordAddr;
  logic [4:0]  lineNum;
  logic [8:0]  memAddr;
  logic        srcReg;
  logic [3:0]  regAddr;
  logic        hSync;
  logic        vSync;
  logic        videoPulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit tickPrev = 1'b0;
  bit expQ[$];
  int mBit = 0;
  int mWord = 0;

  always #2 clk = ~clk;

  scanAddrGen u_dut (.*);

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkAddrs();
    check("R2", "bitAddr", int'(bitAddr), mBit);
    check("R3", "wordAddr", int'(wordAddr), mWord);
    check("R4", "lineNum", int'(lineNum), mWord / 2);
    check("R5", "memAddr", int'(memAddr), int'(pageSel) * 32 + (mWord % 32));
    check("R5/R6", "srcReg", int'(srcReg), (mWord >= 32) ? 1 : 0);
    check("R6", "regAddr", int'(regAddr), (mWord >= 32) ? mWord - 32 : 0);
    check("R7", "hSync", int'(hSync), (mBit == 0 && mWord % 2 == 0) ? 1 : 0);
    check("R8", "vSync", int'(vSync), (mBit == 0 && mWord == 0) ? 1 : 0);
  endtask

  // driver: one slot, then gap idle cycles
  task automatic doSlot(input logic [17:0] md, input logic [17:0] rd,
                        input logic [3:0] pg, input int gap);
    bit e;
    @(negedge clk);
    memData  = md;
    regData  = rd;
    pageSel  = pg;
    slotTick = 1'b1;
    #1;
    checkAddrs();
    e = (mWord >= 32) ? rd[mBit] : md[mBit];
    expQ.push_back(e);
    if (mBit == 17) begin
      mBit = 0;
      mWord = (mWord == 43) ? 0 : mWord + 1;
    end else begin
      mBit++;
    end
    if (gap > 0) begin
      @(negedge clk);
      slotTick = 1'b0;
      #1;
      checkAddrs(); // R2: held through idle cycles
      repeat (gap - 1) @(negedge clk);
    end
  endtask

  // monitor: compare video pulse with scoreboard
  always @(posedge clk) tickPrev <= rstN && slotTick;

  always @(negedge clk) begin
    if (rstN && !done) begin
      if (tickPrev) begin
        if (expQ.size() == 0) begin
          check("R9", "scoreboard underflow", 1, 0);
        end else begin
          bit e;
          e = expQ.pop_front();
          check("R9", "videoPulse after slot", int'(videoPulse), int'(e));
        end
      end else begin
        check("R9", "videoPulse idle", int'(videoPulse), 0);
      end
    end
  end

  initial begin
    logic [17:0] md;
    logic [17:0] rd;
    // reset state
    repeat (3) @(negedge clk);
    check("R1", "bitAddr in reset", int'(bitAddr), 0);
    check("R1", "wordAddr in reset", int'(wordAddr), 0);
    check("R1", "videoPulse in reset", int'(videoPulse), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "bitAddr after reset", int'(bitAddr), 0);
    check("R1", "wordAddr after reset", int'(wordAddr), 0);
    check("R1", "videoPulse after reset", int'(videoPulse), 0);

    // frame 1: random data, mixed gaps
    for (int s = 0; s < 792; s++) begin
      md = 18'($urandom);
      rd = 18'($urandom);
      doSlot(md, rd, 4'((s / 100) % 16), s % 3);
    end
    // frame 2: memory all ones, registers all zero, back to back
    for (int s = 0; s < 792; s++) doSlot('1, '0, 4'd15, 0);
    // frame 3: memory all zero, registers all ones, single gaps
    for (int s = 0; s < 792; s++) doSlot('0, '1, 4'd9, 1);
    // partial frame then reset mid-scan
    for (int s = 0; s < 400; s++) doSlot(18'($urandom), 18'($urandom), 4'd5, 2);
    @(negedge clk);
    slotTick = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    expQ.delete();
    mBit = 0;
    mWord = 0;
    check("R1", "bitAddr after mid reset", int'(bitAddr), 0);
    check("R1", "wordAddr after mid reset", int'(wordAddr), 0);
    rstN = 1'b1;
    for (int s = 0; s < 100; s++) doSlot(18'($urandom), 18'($urandom), 4'd3, 0);
    @(negedge clk);
    slotTick = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", "scoreboard drained", expQ.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule